// File: doc/BRIEF.md
# Per-Core Store Buffer with Ordering Operations

This block sits between one core's load/store request port and a single-ported memory. Stores retire into a FIFO buffer as soon as there is room and drain to memory one at a time, oldest first. Later loads may go to memory ahead of those pending stores, which is the relaxed write-to-read order of total store ordering. A load whose address matches a buffered store takes its data from the youngest such store and does not go to memory at all.

The request stream also carries ordering operations: a read fence, a write fence, a full fence, an acquire (a load with ordering) and a release (a store with ordering). An ordering operation is held at the input, with ready low, until its drain condition holds. Loads and acquires block: no later request is accepted until the load's data has been returned. Memory serves one request at a time and answers each one with a single response pulse. For a write, that pulse is the acknowledge that frees the buffer entry.

Top module: `store_order_buffer`

## Requirements
- R1: After reset, req_ready_o is high for a load, mem_req_valid_o is low and rsp_valid_o is low.
- R2: A store (op code 1) is accepted only while fewer than DEPTH stores are buffered; with DEPTH entries buffered, req_ready_o stays low for a store until a write acknowledge frees the oldest entry.
- R3: A load (op code 0) to an address that no buffered store holds is sent to memory before older buffered stores that have not yet been issued, and its response carries the memory data.
- R4: A load to an address held by one or more buffered stores returns the data of the youngest of them and issues no memory read.
- R5: Buffered stores are written to memory in the order they were accepted, so that the last store to an address leaves its value in memory; an entry leaves the buffer only on the write acknowledge.
- R6: While a load or acquire (op code 5) awaits its response, req_ready_o is low for every op, so no later load is issued before the acquire completes.
- R7: A read fence (op code 2) is not accepted while a load is awaiting its response.
- R8: A write fence (op code 3) is accepted only when the buffer is empty, that is, after every earlier store has been acknowledged.
- R9: A full fence (op code 4) is accepted only when the buffer is empty and no load is awaiting its response.
- R10: A release (op code 6) is accepted only when the buffer is empty and no load is outstanding; it is then written to memory like a store, after all earlier stores.
- R11: At most one memory request is outstanding at a time. A request that is held off by mem_req_ready_i low keeps its valid, address and write flag until it is taken.
- R12: A forwarded load's response appears in the cycle after the load is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Core request accepted when high with valid |
| req_op_i | input | 3 | Op code: 0 load, 1 store, 2 read fence, 3 write fence, 4 full fence, 5 acquire, 6 release, 7 no operation |
| req_addr_i | input | AW | Request address |
| req_data_i | input | DW | Store or release data |
| rsp_valid_o | output | 1 | One-cycle pulse with load or acquire data |
| rsp_data_o | output | DW | Load or acquire data |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory takes the request |
| mem_req_we_o | output | 1 | Memory request is a write |
| mem_req_addr_o | output | AW | Memory address |
| mem_req_wdata_o | output | DW | Memory write data |
| mem_rsp_valid_i | input | 1 | Memory response or write acknowledge, one per request |
| mem_rsp_rdata_i | input | DW | Memory read data |

## Verification
The bound checker watches the drain conditions of every ordering operation on every cycle: an empty buffer at each accepted write fence, full fence and release, no pending load at each accepted full fence. It also checks that ready stays low while a load or acquire is unanswered, that the buffer never overfills, that only one memory request is outstanding, and that a stalled memory request stays stable. Only the directed scenarios can show the data-dependent behaviour. That covers which value a forwarded load returns, whether a load's read really overtakes older stores in the memory log, the program order of same-address writes, and the cycle in which a forwarded response appears.

// File: rtl/sob_pkg.sv
package sob_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_RFENCE = 3'd2,
    OP_WFENCE = 3'd3,
    OP_FFENCE = 3'd4,
    OP_ACQ    = 3'd5,
    OP_REL    = 3'd6,
    OP_NOP    = 3'd7
  } sob_op_e;
endpackage

// File: rtl/sob_queue.sv
module sob_queue #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic [AW-1:0] lk_addr_i,
  output logic          lk_hit_o,
  output logic [DW-1:0] lk_data_o,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= nxt(tail_q);
      if (pop_i)  head_q <= nxt(head_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[tail_q] <= push_addr_i;
      data_q[tail_q] <= push_data_i;
    end
  end

  // walk oldest to youngest; last match wins
  always_comb begin
    logic [PW-1:0] idx;
    lk_hit_o  = 1'b0;
    lk_data_o = '0;
    idx       = head_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < cnt_q && addr_q[idx] == lk_addr_i) begin
        lk_hit_o  = 1'b1;
        lk_data_o = data_q[idx];
      end
      idx = nxt(idx);
    end
  end

  assign head_addr_o = addr_q[head_q];
  assign head_data_o = data_q[head_q];
  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q == CW'(DEPTH));
  assign count_o     = cnt_q;
endmodule

// File: rtl/sob_mem_arb.sv
module sob_mem_arb #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_pend_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          wr_pend_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          rd_fire_o,
  output logic          rd_done_o,
  output logic [DW-1:0] rd_data_o,
  output logic          wr_done_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_we_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_wdata_o,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_rdata_i
);
  logic busy_q, is_wr_q, lock_q, lock_rd_q;
  logic sel_rd, fire;

  // a stalled request keeps its choice until taken
  assign sel_rd          = lock_q ? lock_rd_q : rd_pend_i;
  assign mem_req_valid_o = !busy_q && (sel_rd || wr_pend_i);
  assign mem_req_we_o    = !sel_rd;
  assign mem_req_addr_o  = sel_rd ? rd_addr_i : wr_addr_i;
  assign mem_req_wdata_o = wr_data_i;
  assign fire            = mem_req_valid_o && mem_req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      is_wr_q   <= 1'b0;
      lock_q    <= 1'b0;
      lock_rd_q <= 1'b0;
    end else begin
      if (fire) begin
        busy_q  <= 1'b1;
        is_wr_q <= !sel_rd;
        lock_q  <= 1'b0;
      end else if (mem_req_valid_o) begin
        lock_q    <= 1'b1;
        lock_rd_q <= sel_rd;
      end
      if (busy_q && mem_rsp_valid_i) busy_q <= 1'b0;
    end
  end

  assign rd_fire_o = fire && sel_rd;
  assign rd_done_o = busy_q && mem_rsp_valid_i && !is_wr_q;
  assign wr_done_o = busy_q && mem_rsp_valid_i && is_wr_q;
  assign rd_data_o = mem_rsp_rdata_i;
endmodule

// File: rtl/store_order_buffer.sv
module store_order_buffer
  import sob_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [2:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_we_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_wdata_o,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_rdata_i
);
  sob_op_e       op;
  logic          acc, push, take_ld, op_ok, ld_busy;
  logic          ld_pend_q, ld_wait_q, rsp_v_q;
  logic [AW-1:0] ld_addr_q;
  logic [DW-1:0] rsp_d_q;
  logic          q_hit, q_empty, q_full;
  logic [DW-1:0] q_hit_data, q_head_data, rd_data;
  logic [AW-1:0] q_head_addr;
  logic [CW-1:0] q_count;
  logic          rd_fire, rd_done, wr_done;

  assign op      = sob_op_e'(req_op_i);
  assign ld_busy = ld_pend_q || ld_wait_q;

  always_comb begin
    unique case (op)
      OP_STORE:                   op_ok = !q_full;
      OP_WFENCE, OP_FFENCE, OP_REL: op_ok = q_empty;
      default:                    op_ok = 1'b1;
    endcase
  end

  // loads block, so "no read pending" is already implied by !ld_busy
  assign req_ready_o = !ld_busy && op_ok;
  assign acc         = req_valid_i && req_ready_o;
  assign push        = acc && (op == OP_STORE || op == OP_REL);
  assign take_ld     = acc && (op == OP_LOAD || op == OP_ACQ);

  sob_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_addr_i (req_addr_i),
    .push_data_i (req_data_i),
    .pop_i       (wr_done),
    .lk_addr_i   (req_addr_i),
    .lk_hit_o    (q_hit),
    .lk_data_o   (q_hit_data),
    .head_addr_o (q_head_addr),
    .head_data_o (q_head_data),
    .empty_o     (q_empty),
    .full_o      (q_full),
    .count_o     (q_count)
  );

  sob_mem_arb #(.AW(AW), .DW(DW)) i_arb (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .rd_pend_i       (ld_pend_q),
    .rd_addr_i       (ld_addr_q),
    .wr_pend_i       (!q_empty),
    .wr_addr_i       (q_head_addr),
    .wr_data_i       (q_head_data),
    .rd_fire_o       (rd_fire),
    .rd_done_o       (rd_done),
    .rd_data_o       (rd_data),
    .wr_done_o       (wr_done),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_we_o    (mem_req_we_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_wdata_o (mem_req_wdata_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_rdata_i (mem_rsp_rdata_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_pend_q <= 1'b0;
      ld_wait_q <= 1'b0;
      ld_addr_q <= '0;
      rsp_v_q   <= 1'b0;
      rsp_d_q   <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      if (take_ld && q_hit) begin
        rsp_v_q <= 1'b1;
        rsp_d_q <= q_hit_data;
      end else if (take_ld) begin
        ld_pend_q <= 1'b1;
        ld_addr_q <= req_addr_i;
      end
      if (rd_fire) begin
        ld_pend_q <= 1'b0;
        ld_wait_q <= 1'b1;
      end
      if (rd_done) begin
        ld_wait_q <= 1'b0;
        rsp_v_q   <= 1'b1;
        rsp_d_q   <= rd_data;
      end
    end
  end

  assign rsp_valid_o = rsp_v_q;
  assign rsp_data_o  = rsp_d_q;
endmodule

// File: rtl/sob_checker.sv
module sob_checker #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [2:0]    req_op_i,
  input logic          rsp_valid_o,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic          mem_req_we_o,
  input logic [AW-1:0] mem_req_addr_o,
  input logic          mem_rsp_valid_i,
  input logic [CW-1:0] q_count
);
  logic acc, ld_out_q, mem_out_q;
  assign acc = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_out_q  <= 1'b0;
      mem_out_q <= 1'b0;
    end else begin
      if (acc && (req_op_i == 3'd0 || req_op_i == 3'd5)) ld_out_q <= 1'b1;
      else if (rsp_valid_o) ld_out_q <= 1'b0;
      if (mem_req_valid_o && mem_req_ready_i) mem_out_q <= 1'b1;
      else if (mem_rsp_valid_i) mem_out_q <= 1'b0;
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count <= CW'(DEPTH));
  p_full_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_count == CW'(DEPTH) && req_op_i == 3'd1) |-> !req_ready_o);
  p_load_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_out_q && !rsp_valid_o) |-> !req_ready_o);
  p_rfence_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_op_i == 3'd2) |-> (!ld_out_q || rsp_valid_o));
  p_wfence_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_op_i == 3'd3) |-> q_count == '0);
  p_ffence_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_op_i == 3'd4) |-> (q_count == '0 && (!ld_out_q || rsp_valid_o)));
  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_op_i == 3'd6) |-> (q_count == '0 && (!ld_out_q || rsp_valid_o)));
  p_single_out_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_out_q |-> !mem_req_valid_o);
  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o)));
endmodule

bind store_order_buffer sob_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_sob_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_op_i        (req_op_i),
  .rsp_valid_o     (rsp_valid_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_we_o    (mem_req_we_o),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .q_count         (q_count)
);

// File: tb/test_store_order_buffer.sv
module test_store_order_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 16, DEPTH = 8, LAT = 3;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0, req_ready;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          m_valid, m_ready = 1'b1, m_we, m_rspv;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata, m_rdata;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  store_order_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_store_order_buffer (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_data_i(req_data),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .mem_req_valid_o(m_valid), .mem_req_ready_i(m_ready), .mem_req_we_o(m_we),
    .mem_req_addr_o(m_addr), .mem_req_wdata_o(m_wdata),
    .mem_rsp_valid_i(m_rspv), .mem_rsp_rdata_i(m_rdata)
  );

  // fixed-latency memory model with request log
  logic [DW-1:0] mem_m [256];
  logic          log_we [128];
  logic [AW-1:0] log_addr [128];
  logic [DW-1:0] log_data [128];
  int            log_n, acks, overlap, cnt;
  logic [DW-1:0] p_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_m[i] <= DW'(16'h1000 + i);
      cnt <= 0; m_rspv <= 1'b0; m_rdata <= '0; log_n <= 0; acks <= 0; overlap <= 0; p_rd <= '0;
    end else begin
      m_rspv <= 1'b0;
      if (cnt != 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) begin m_rspv <= 1'b1; m_rdata <= p_rd; acks <= acks + 1; end
      end
      if (m_valid && m_ready) begin
        if (cnt != 0 || m_rspv) overlap <= overlap + 1;
        cnt <= LAT;
        p_rd <= mem_m[m_addr];
        if (m_we) mem_m[m_addr] <= m_wdata;
        if (log_n < 128) begin
          log_we[log_n] <= m_we; log_addr[log_n] <= m_addr; log_data[log_n] <= m_wdata;
          log_n <= log_n + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic present(input logic [2:0] op, input int a, input int d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_data = DW'(d);
  endtask

  task automatic wait_acc();
    #1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send(input logic [2:0] op, input int a, input int d);
    present(op, a, d);
    wait_acc();
  endtask

  task automatic wait_rsp(output logic [DW-1:0] d);
    int t = 0;
    while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
    d = rsp_data;
  endtask

  task automatic stay_blocked(input string req);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!req_ready, req, req_ready, 0);
    end
  endtask

  task automatic drain();
    @(negedge clk); m_ready = 1'b1;
    repeat (80) @(negedge clk);
  endtask

  function automatic int find_log(input int from, input bit we, input int a, input int d, input bit use_d);
    for (int i = from; i < log_n; i++)
      if (log_we[i] == we && log_addr[i] == AW'(a) && (!use_d || log_data[i] == DW'(d))) return i;
    return -1;
  endfunction

  task automatic t_reset();
    req_op = 3'd0; #1;
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(m_valid == 1'b0, "R1 mem_req_valid", m_valid, 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_bypass();
    int base = log_n, ir, iw;
    logic [DW-1:0] d;
    for (int i = 1; i <= 4; i++) send(3'd1, i, 16'hA0 + i);
    send(3'd0, 8'h60, 0);
    wait_rsp(d);
    chk(d == 16'h1060, "R3 load data", d, 16'h1060);
    ir = find_log(base, 0, 8'h60, 0, 0);
    iw = find_log(base, 1, 4, 0, 0);
    drain();
    iw = find_log(base, 1, 4, 0, 0);
    chk(ir >= 0 && iw > ir, "R3 read before older store", ir, iw);
    chk(overlap == 0, "R11 single outstanding", overlap, 0);
  endtask

  task automatic t_forward();
    int base, i1, i2;
    @(negedge clk); m_ready = 1'b0;
    send(3'd1, 7, 16'h11);
    send(3'd1, 7, 16'h22);
    base = log_n;
    send(3'd0, 7, 0);
    chk(rsp_valid == 1'b1, "R12 forward next cycle", rsp_valid, 1);
    chk(rsp_data == 16'h22, "R4 youngest store data", rsp_data, 16'h22);
    chk(m_valid && m_we && m_addr == 8'd7, "R11 stalled request held", m_addr, 7);
    drain();
    chk(find_log(base, 0, 7, 0, 0) < 0, "R4 no memory read", find_log(base, 0, 7, 0, 0), -1);
    i1 = find_log(0, 1, 7, 16'h11, 1);
    i2 = find_log(0, 1, 7, 16'h22, 1);
    chk(i1 >= 0 && i2 > i1, "R5 same-address order", i1, i2);
    chk(mem_m[7] == 16'h22, "R5 final value", mem_m[7], 16'h22);
  endtask

  task automatic t_full();
    int i0, i9;
    @(negedge clk); m_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) send(3'd1, 8'h10 + i, 16'h100 + i);
    present(3'd1, 8'h20, 16'h120);
    stay_blocked("R2 full stall");
    @(negedge clk); m_ready = 1'b1;
    wait_acc();
    drain();
    i0 = find_log(0, 1, 8'h10, 0, 0);
    i9 = find_log(0, 1, 8'h20, 0, 0);
    chk(i0 >= 0 && i9 > i0, "R5 FIFO drain order", i0, i9);
    chk(mem_m[8'h20] == 16'h120, "R2 stalled store written", mem_m[8'h20], 16'h120);
  endtask

  task automatic t_fence(input logic [2:0] op, input int a, input string req);
    int a0;
    @(negedge clk); m_ready = 1'b0;
    send(3'd1, a, 16'h300 + a);
    a0 = acks;
    present(op, 8'h41, 16'h410);
    stay_blocked(req);
    @(negedge clk); m_ready = 1'b1;
    wait_acc();
    chk(acks - a0 >= 1, req, acks - a0, 1);
    drain();
  endtask

  task automatic t_release();
    int i1, i2;
    t_fence(3'd6, 8'h40, "R10 release waits for drain");
    i1 = find_log(0, 1, 8'h40, 0, 0);
    i2 = find_log(0, 1, 8'h41, 0, 0);
    chk(i1 >= 0 && i2 > i1, "R10 release after older store", i1, i2);
    chk(mem_m[8'h41] == 16'h410, "R10 release value", mem_m[8'h41], 16'h410);
  endtask

  task automatic t_acquire();
    logic [DW-1:0] d;
    @(negedge clk); m_ready = 1'b0;
    send(3'd5, 8'h50, 0);
    present(3'd0, 8'h51, 0);
    stay_blocked("R6 load held behind acquire");
    @(negedge clk); m_ready = 1'b1;
    wait_rsp(d);
    chk(d == 16'h1050, "R6 acquire data", d, 16'h1050);
    wait_acc();
    wait_rsp(d);
    chk(d == 16'h1051, "R6 later load data", d, 16'h1051);
  endtask

  task automatic t_rfence();
    logic [DW-1:0] d;
    @(negedge clk); m_ready = 1'b0;
    send(3'd0, 8'h52, 0);
    present(3'd2, 0, 0);
    stay_blocked("R7 read fence held");
    @(negedge clk); m_ready = 1'b1;
    wait_rsp(d);
    chk(d == 16'h1052, "R7 earlier load data", d, 16'h1052);
    wait_acc();
    chk(req_ready == 1'b1, "R7 fence accepted", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_forward();
    t_full();
    t_fence(3'd3, 8'h30, "R8 write fence waits for ack");
    t_fence(3'd4, 8'h31, "R9 full fence waits for ack");
    t_release();
    t_acquire();
    t_rfence();
    chk(overlap == 0, "R11 single outstanding at end", overlap, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule